// File: doc/BRIEF.md
# Codec Control-Slot Register Access Engine

This block performs register accesses to an external audio codec through the control slots of a serial audio link. Software first loads a data word into the slot-2 transmit register. It then writes the slot-1 transmit register. The slot-1 word holds a read/write flag and a 7-bit codec register index, and writing it starts the access. A write access carries the index and a 16-bit data field to the codec register port. A read access returns a 16-bit value. The engine posts that value into two receive words in 20-bit slot format and updates a slot flag vector.

The codec side is a request/acknowledge port, and only one access is in flight at a time. Serial bit timing and the codec's internal registers are outside this block. Writing the control register with its enable bit low returns every register and flag to its reset value.

Top module: `codec_slot_engine`

## Requirements
- R1: After reset, `flags` reads 7'h07 and `cdc_req`, `rx1_word` and `rx2_word` are zero. Flag bits are: bit0 slot-1 transmit empty, bit1 slot-2 transmit empty, bit2 both-slots transmit empty, bit3 slot-1 receive busy, bit4 slot-2 receive busy, bit5 slot-1 receive valid, bit6 slot-2 receive valid.
- R2: A write with `reg_sel`=1 (slot 2) stores the word and clears flag bits 1 and 2. It raises no request.
- R3: A write with `reg_sel`=0 (slot 1) while no access is outstanding clears flag bits 0 and 2. On the next clock it raises `cdc_req` with `cdc_rd` set to word bit 19, `cdc_idx` set to word bits 18:12, and `cdc_wdata` set to bits 19:4 of the stored slot-2 word.
- R4: While a read access is outstanding, flag bits 3 and 4 are set.
- R5: When a read is acknowledged, `rx1_word` becomes the slot-1 word with bit 19 cleared and `rx2_word` becomes `cdc_rdata` shifted left by 4. Flag bits 3 and 4 clear, flag bits 5 and 6 set, and `cdc_req` drops.
- R6: When a write access is acknowledged, `cdc_req` drops and the receive words and receive flags are unchanged.
- R7: `cdc_req`, `cdc_rd`, `cdc_idx` and `cdc_wdata` hold steady until `cdc_ack`. A slot-1 write made during that time is ignored.
- R8: A write with `reg_sel`=2 and bit 0 low returns every register and flag to the R1 state and abandons any outstanding access. A write with bit 0 high has no effect.
- R9: `cdc_ack` has no effect while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 slot-1 transmit, 1 slot-2 transmit, 2 control |
| reg_wdata | input | 20 | Write data (slot word; control enable in bit 0) |
| cdc_req | output | 1 | Codec access request |
| cdc_rd | output | 1 | 1 read, 0 write |
| cdc_idx | output | 7 | Codec register index |
| cdc_wdata | output | 16 | Codec write data |
| cdc_ack | input | 1 | Codec acknowledge |
| cdc_rdata | input | 16 | Codec read data, sampled on acknowledge |
| rx1_word | output | 20 | Slot-1 receive word |
| rx2_word | output | 20 | Slot-2 receive word |
| flags | output | 7 | Slot flag vector |

## Verification
The bench builds the block with its default widths: a 20-bit slot, a 7-bit index and 16-bit data. With these widths the read flag sits in bit 19 and the data is padded by 4 bits, so the field positions the codec depends on are checked directly. A table of slot-word pairs exercises all-ones and all-zeros fields and the extreme indices. It covers both directions and confirms that slot-1 bits 11:0 come back in the echo. Directed cases cover a slot-1 write while an access is outstanding, an acknowledge with no request, and a clear that arrives in the middle of a read.

// File: rtl/codec_slot_engine.sv
module codec_slot_engine #(
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [SLOT_W-1:0] reg_wdata,
  output logic              cdc_req,
  output logic              cdc_rd,
  output logic [IDX_W-1:0]  cdc_idx,
  output logic [DATA_W-1:0] cdc_wdata,
  input  logic              cdc_ack,
  input  logic [DATA_W-1:0] cdc_rdata,
  output logic [SLOT_W-1:0] rx1_word,
  output logic [SLOT_W-1:0] rx2_word,
  output logic [6:0]        flags
);
  localparam int RD_BIT  = SLOT_W - 1;
  localparam int IDX_TOP = SLOT_W - 2;
  localparam int PAD     = SLOT_W - DATA_W;
  localparam int F_TX1E = 0, F_TX2E = 1, F_TXBE = 2;
  localparam int F_RX1B = 3, F_RX2B = 4, F_RX1V = 5, F_RX2V = 6;
  localparam logic [6:0] FLAGS_RST = 7'h07;
  localparam logic [1:0] SEL_S1 = 2'd0, SEL_S2 = 2'd1, SEL_CTL = 2'd2;

  logic [SLOT_W-1:0] s1_word, s2_word;
  logic wr_s1, wr_s2, clr, launch, done;

  assign wr_s1  = reg_wr && reg_sel == SEL_S1;
  assign wr_s2  = reg_wr && reg_sel == SEL_S2;
  assign clr    = reg_wr && reg_sel == SEL_CTL && !reg_wdata[0];
  assign launch = wr_s1 && !cdc_req;
  assign done   = cdc_req && cdc_ack;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s1_word   <= '0;
      s2_word   <= '0;
      rx1_word  <= '0;
      rx2_word  <= '0;
      flags     <= FLAGS_RST;
      cdc_req   <= 1'b0;
      cdc_rd    <= 1'b0;
      cdc_idx   <= '0;
      cdc_wdata <= '0;
    end else begin
      if (wr_s2) begin
        s2_word        <= reg_wdata;
        flags[F_TX2E]  <= 1'b0;
        flags[F_TXBE]  <= 1'b0;
      end
      if (launch) begin
        s1_word        <= reg_wdata;
        flags[F_TX1E]  <= 1'b0;
        flags[F_TXBE]  <= 1'b0;
        cdc_req        <= 1'b1;
        cdc_rd         <= reg_wdata[RD_BIT];
        cdc_idx        <= reg_wdata[IDX_TOP -: IDX_W];
        cdc_wdata      <= s2_word[RD_BIT -: DATA_W];
        if (reg_wdata[RD_BIT]) begin
          flags[F_RX1B] <= 1'b1;
          flags[F_RX2B] <= 1'b1;
        end
      end
      if (done) begin
        cdc_req <= 1'b0;
        if (cdc_rd) begin
          rx1_word      <= s1_word & ~(SLOT_W'(1) << RD_BIT);
          rx2_word      <= {cdc_rdata, {PAD{1'b0}}};
          flags[F_RX1B] <= 1'b0;
          flags[F_RX2B] <= 1'b0;
          flags[F_RX1V] <= 1'b1;
          flags[F_RX2V] <= 1'b1;
        end
      end
    end
  end

  // R1 / R8: clear restores the reset picture
  a_r8_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> flags == FLAGS_RST && !cdc_req && rx1_word == '0 && rx2_word == '0);

  a_r3_launch_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s1 && !cdc_req) |=> cdc_req && cdc_rd == $past(reg_wdata[RD_BIT]) && !flags[F_TX1E]);

  a_r4_busy_while_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_req && cdc_rd) |-> flags[F_RX1B] && flags[F_RX2B]);

  a_r5_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cdc_rd && !reg_wr) |=> !cdc_req && flags[F_RX1V] && flags[F_RX2V]
      && !flags[F_RX1B] && !flags[F_RX2B] && !rx1_word[RD_BIT]);

  a_r6_write_ack_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cdc_rd && !reg_wr) |=> !cdc_req && $stable(rx1_word) && $stable(rx2_word));

  a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cdc_req && !cdc_ack && !clr) |=> cdc_req && $stable(cdc_idx) && $stable(cdc_rd)
      && $stable(cdc_wdata));

  a_r9_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!cdc_req && cdc_ack && !reg_wr) |=> $stable(rx1_word) && $stable(rx2_word) && !cdc_req);
endmodule

// File: tb/codec_slot_engine_tb.sv
module codec_slot_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [19:0] reg_wdata = '0;
  logic        cdc_ack = 1'b0;
  logic [15:0] cdc_rdata = '0;
  logic        cdc_req, cdc_rd;
  logic [6:0]  cdc_idx;
  logic [15:0] cdc_wdata;
  logic [19:0] rx1_word, rx2_word;
  logic [6:0]  flags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  codec_slot_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cdc_req(cdc_req), .cdc_rd(cdc_rd), .cdc_idx(cdc_idx), .cdc_wdata(cdc_wdata),
    .cdc_ack(cdc_ack), .cdc_rdata(cdc_rdata),
    .rx1_word(rx1_word), .rx2_word(rx2_word), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {slot1 word, slot2 word, codec read data}
  localparam logic [55:0] VEC [6] = '{
    {20'hA5123, 20'h12340, 16'hBEEF},
    {20'h1C000, 20'hFFFFF, 16'h0000},
    {20'hFFFFF, 20'h00000, 16'hFFFF},
    {20'h00000, 20'hABCD5, 16'h5555},
    {20'h80000, 20'h00000, 16'h0001},
    {20'h7F00F, 20'h5A5A0, 16'hAAAA}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic ack(input logic [15:0] d);
    @(negedge clk);
    cdc_ack = 1'b1; cdc_rdata = d;
    @(negedge clk);
    cdc_ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] s1, s2, prev1, prev2;
    logic [15:0] rd;
    logic valid;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", flags, 7'h07);
    chk("R1 req", cdc_req, 0);
    chk("R1 rx1", rx1_word, 0);
    chk("R1 rx2", rx2_word, 0);

    wr(2'd1, 20'h33330);
    chk("R2 flags after slot2", flags, 7'h01);
    chk("R2 no request", cdc_req, 0);

    prev1 = '0; prev2 = '0; valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      s1 = VEC[i][55:36]; s2 = VEC[i][35:16]; rd = VEC[i][15:0];
      wr(2'd1, s2);
      wr(2'd0, s1);
      chk("R3 req", cdc_req, 1);
      chk("R3 rd", cdc_rd, s1[19]);
      chk("R3 idx", cdc_idx, s1[18:12]);
      chk("R3 wdata", cdc_wdata, s2[19:4]);
      chk("R4 flags outstanding", flags, {valid, valid, s1[19], s1[19], 3'b000});
      repeat (3) @(negedge clk);
      chk("R7 held", {cdc_req, cdc_rd, cdc_idx, cdc_wdata}, {1'b1, s1[19], s1[18:12], s2[19:4]});
      ack(rd);
      chk("R5 R6 req dropped", cdc_req, 0);
      if (s1[19]) begin
        valid = 1'b1;
        prev1 = s1 & 20'h7FFFF;
        prev2 = {rd, 4'h0};
        chk("R5 rx1 echo", rx1_word, prev1);
        chk("R5 rx2 data", rx2_word, prev2);
      end else begin
        chk("R6 rx1 kept", rx1_word, prev1);
        chk("R6 rx2 kept", rx2_word, prev2);
      end
      chk("R5 R6 flags", flags, {valid, valid, 5'b00000});
    end

    // R7: slot-1 write while outstanding is ignored
    wr(2'd1, 20'h11110);
    wr(2'd0, 20'h81000);
    wr(2'd0, 20'h7F123);
    chk("R7 idx unchanged", cdc_idx, 7'h01);
    chk("R7 rd unchanged", cdc_rd, 1);
    ack(16'h1234);
    chk("R7 echo of first word", rx1_word, 20'h01000);
    chk("R5 rx2", rx2_word, 20'h12340);

    // R9: stray acknowledge
    ack(16'hDEAD);
    chk("R9 rx2 kept", rx2_word, 20'h12340);
    chk("R9 no req", cdc_req, 0);

    // R8: enable high write does nothing
    wr(2'd2, 20'h00001);
    chk("R8 enable write flags", flags, 7'h60);
    chk("R8 enable write rx1", rx1_word, 20'h01000);

    // R8: clear during outstanding read
    wr(2'd0, 20'h85000);
    chk("R4 busy before clear", flags, 7'h78);
    wr(2'd2, 20'h00000);
    chk("R8 flags", flags, 7'h07);
    chk("R8 req", cdc_req, 0);
    chk("R8 rx1", rx1_word, 0);
    chk("R8 rx2", rx2_word, 0);
    ack(16'hCAFE);
    chk("R9 ack after clear", rx2_word, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule